// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column addresses of one SDRAM read or write burst, one address per clock. A start pulse captures an 8-bit starting column together with the burst settings. The settings are a 3-bit length code, an interleave flag, a single-beat-write flag and a read/write flag. From the following cycle on, the block emits the burst's columns with a valid flag, and raises a last flag on the final beat.

Fixed bursts of 2, 4 or 8 beats stay inside a block of columns aligned to the burst length. The bits above the block are held, and only the low bits step. They step in either sequential or interleaved order, and they wrap back to the bottom of the block. A full-page burst walks all 256 columns in sequential order and keeps wrapping until a terminate pulse ends it. A new start pulse takes over at once, even in the middle of a burst.

The column stream has no back-pressure input. Each emitted address is meant to be issued in the cycle it is shown, so a consumer cannot stall it and can only cut it short with a terminate pulse.

Top module: `sdram_colseq`

## Requirements
- R1: While reset is held low, and in the first cycle after its release, `col_valid_o` and `col_last_o` are low.
- R2: A start pulse sampled at a clock edge makes `col_valid_o` high after that edge, with `col_o` equal to the sampled starting column.
- R3: The length code maps as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. Codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R4: In a sequential fixed burst of length L, beat k has low bits (start + k) mod L. The column bits above log2(L) stay equal to those of the start column, so the burst wraps inside its aligned block.
- R5: With the interleave flag set, beat k of a fixed burst of length L has low bits (start XOR k). The upper bits are held as in R4.
- R6: A full-page burst advances the whole 8-bit column by one each beat, wrapping from 255 to 0. It never raises the last flag and ignores the interleave flag.
- R7: When the single-beat-write flag and the write flag are both high at start, the burst is 1 beat whatever the length code. A read with the single-beat-write flag high uses the programmed length.
- R8: A terminate pulse sampled during a burst makes `col_valid_o` low after that edge. If start and terminate are sampled together, the start wins.
- R9: A start pulse during a running burst discards the old burst, and the new burst's first column appears after that same edge.
- R10: `col_last_o` is high only on the final beat of a fixed burst, and `col_valid_o` falls after that beat unless a new start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a burst with the settings below |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_single_i | input | 1 | Single-beat write mode |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| term_i | input | 1 | Stop the current burst |
| col_o | output | 8 | Column address of the current beat |
| col_valid_o | output | 1 | `col_o` holds a burst beat |
| col_last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The hardest situations to reach are the ones where two events meet at one edge. A full-page burst must cross the 255-to-0 boundary. A start must arrive exactly as another burst is on a middle beat. A terminate must arrive in the same cycle as a start. The stimulus reaches them directly. It starts a full-page burst at column 254 and lets it run past one full wrap. It issues a fresh start three beats into an 8-beat interleaved burst. It pulses start and terminate together. At every clock a behavioural model predicts the valid flag, the last flag and the column, and the bench compares them with the outputs.

// File: rtl/sdram_colseq_pkg.sv
package sdram_colseq_pkg;
  // width of the log2 burst length field (max fixed length 2**(2**LG_W-1))
  localparam int LG_W = 2;

  typedef struct packed {
    logic            full;  // full-page burst
    logic [LG_W-1:0] lg;    // log2 of fixed length
  } blen_t;
endpackage

// File: rtl/colseq_len_dec.sv
module colseq_len_dec
  import sdram_colseq_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] FULL_CODE = 3'b111
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              is_write_i,
  input  logic              wr_single_i,
  output blen_t             blen_o
);
  always_comb begin
    blen_o = '0;
    if (!(is_write_i && wr_single_i)) begin
      if (code_i == FULL_CODE) begin
        blen_o.full = 1'b1;
      end else if (code_i < CODE_W'(2 ** LG_W)) begin
        blen_o.lg = LG_W'(code_i);
      end
    end
  end
endmodule

// File: rtl/colseq_beat_ctr.sv
module colseq_beat_ctr
  import sdram_colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  blen_t            blen_i,
  output logic             active_o,
  output logic             last_o,
  output logic             full_o,
  output logic [LG_W-1:0]  lg_o,
  output logic [COL_W-1:0] beat_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] lim;

  assign lim    = (ONE << lg_o) - ONE;
  assign last_o = active_o && !full_o && (beat_o == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      full_o   <= 1'b0;
      lg_o     <= '0;
      beat_o   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      full_o   <= blen_i.full;
      lg_o     <= blen_i.lg;
      beat_o   <= '0;
    end else if (active_o) begin
      if (term_i || last_o) active_o <= 1'b0;
      else                  beat_o   <= beat_o + ONE;
    end
  end

  // R10
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !active_o);
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen
  import sdram_colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ilv_i,
  input  logic             full_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] sc_q;
  logic             ilv_q;
  logic [COL_W-1:0] mask, low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q  <= '0;
      ilv_q <= 1'b0;
    end else if (start_i) begin
      sc_q  <= col_i;
      ilv_q <= ilv_i;
    end
  end

  always_comb begin
    mask  = full_i ? '1 : ((ONE << lg_i) - ONE);
    low   = ilv_q ? (sc_q ^ beat_i) : (sc_q + beat_i);
    col_o = (sc_q & ~mask) | (low & mask);
  end
endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq
  import sdram_colseq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ilv_i,
  input  logic              wr_single_i,
  input  logic              is_write_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              col_last_o
);
  localparam int BLK_LO = 2 ** LG_W - 1;

  blen_t            blen;
  logic             full_w;
  logic [LG_W-1:0]  lg_w;
  logic [COL_W-1:0] beat_w;

  colseq_len_dec #(.CODE_W(CODE_W)) u_dec (
    .code_i      (len_code_i),
    .is_write_i  (is_write_i),
    .wr_single_i (wr_single_i),
    .blen_o      (blen)
  );

  colseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .term_i   (term_i),
    .blen_i   (blen),
    .active_o (col_valid_o),
    .last_o   (col_last_o),
    .full_o   (full_w),
    .lg_o     (lg_w),
    .beat_o   (beat_w)
  );

  colseq_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_i   (start_col_i),
    .ilv_i   (ilv_i && !blen.full),
    .full_i  (full_w),
    .lg_i    (lg_w),
    .beat_i  (beat_w),
    .col_o   (col_o)
  );

  // R2
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> col_valid_o && col_o == $past(start_col_i));
  // R8
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_i && !start_i |=> !col_valid_o);
  // R4
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !full_w && !start_i |=>
      col_o[COL_W-1:BLK_LO] == $past(col_o[COL_W-1:BLK_LO]));
  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && full_w && !start_i && !term_i |=>
      col_o == COL_W'($past(col_o) + 1'b1) && !col_last_o);
endmodule

// File: tb/sdram_colseq_test.sv
`timescale 1ns/1ps
module sdram_colseq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ilv = 1'b0, wrs = 1'b0, wr = 1'b0, term = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] code = '0;
  logic [7:0] col;
  logic valid, last;

  int total = 0, bad = 0;
  string req = "R1";

  // reference model state
  int m_act = 0, m_k = 0, m_s = 0, m_len = 1, m_ilv = 0;

  always #4 clk = ~clk;

  sdram_colseq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_col_i(scol),
    .len_code_i(code), .ilv_i(ilv), .wr_single_i(wrs), .is_write_i(wr),
    .term_i(term), .col_o(col), .col_valid_o(valid), .col_last_o(last)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0;
    end else if (start) begin
      m_act = 1; m_k = 0; m_s = int'(scol);
      if (wr && wrs)        m_len = 1;
      else if (code == 3'd7) m_len = 0;
      else if (code <= 3'd3) m_len = 1 << code;
      else                   m_len = 1;
      m_ilv = (m_len != 0) ? int'(ilv) : 0;
    end else if (m_act != 0) begin
      if (term) m_act = 0;
      else if (m_len != 0 && m_k == m_len - 1) m_act = 0;
      else m_k = (m_k + 1) % 256;
    end
  end

  function automatic int exp_col();
    int base, off;
    if (m_len == 0) return (m_s + m_k) % 256;
    base = m_s - (m_s % m_len);
    off  = m_s % m_len;
    if (m_ilv != 0) return base + (off ^ m_k);
    return base + ((off + m_k) % m_len);
  endfunction

  task automatic compare();
    int ev, el;
    ev = m_act;
    el = (m_act != 0 && m_len != 0 && m_k == m_len - 1) ? 1 : 0;
    total++;
    if (int'(valid) != ev) begin
      bad++; $display("FAIL %s valid actual=%0d expected=%0d", req, valid, ev);
    end
    total++;
    if (int'(last) != el) begin
      bad++; $display("FAIL %s last actual=%0d expected=%0d", req, last, el);
    end
    if (ev != 0) begin
      total++;
      if (int'(col) != exp_col()) begin
        bad++; $display("FAIL %s col actual=%0h expected=%0h", req, col, exp_col());
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    start = 1'b0;
    term  = 1'b0;
  endtask

  task automatic go(input logic [7:0] c, input logic [2:0] lc, input logic i,
                    input logic w, input logic s);
    scol = c; code = lc; ilv = i; wr = w; wrs = s; start = 1'b1;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req = "R1";
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    tick();
    req = "R4 R2 R10";   go(8'h45, 3'b010, 1'b0, 1'b0, 1'b0); idle(5);
    req = "R5 R3";       go(8'h2D, 3'b011, 1'b1, 1'b0, 1'b0); idle(9);
    req = "R4 seq8";     go(8'hF6, 3'b011, 1'b0, 1'b0, 1'b0); idle(9);
    req = "R3 len2";     go(8'h13, 3'b001, 1'b0, 1'b0, 1'b0); idle(3);
    req = "R5 len4";     go(8'h82, 3'b010, 1'b1, 1'b0, 1'b0); idle(5);
    req = "R3 len1";     go(8'h77, 3'b000, 1'b0, 1'b0, 1'b0); idle(2);
    req = "R3 rsvd";     go(8'h31, 3'b101, 1'b0, 1'b0, 1'b0); idle(2);
    req = "R3 rsvd6";    go(8'h31, 3'b110, 1'b1, 1'b0, 1'b0); idle(2);
    req = "R6";          go(8'hFE, 3'b111, 1'b1, 1'b0, 1'b0); idle(262);
    req = "R8 page";     term = 1'b1; tick(); idle(3);
    req = "R7 write";    go(8'h5B, 3'b011, 1'b0, 1'b1, 1'b1); idle(3);
    req = "R7 read";     go(8'h5B, 3'b011, 1'b0, 1'b0, 1'b1); idle(9);
    req = "R7 wr-page";  go(8'h10, 3'b111, 1'b0, 1'b1, 1'b1); idle(3);
    req = "R7 wr-multi"; go(8'h10, 3'b010, 1'b0, 1'b1, 1'b0); idle(5);
    req = "R8 fixed";    go(8'hA0, 3'b011, 1'b0, 1'b0, 1'b0); idle(2);
    term = 1'b1; tick(); idle(3);
    req = "R9";          go(8'h2D, 3'b011, 1'b1, 1'b0, 1'b0); idle(3);
    go(8'hC3, 3'b010, 1'b0, 1'b0, 1'b0); idle(1);
    go(8'h64, 3'b011, 1'b0, 1'b0, 1'b0); idle(9);
    req = "R8 both";     term = 1'b1; go(8'h19, 3'b010, 1'b1, 1'b0, 1'b0); idle(5);
    req = "R10 b2b";     go(8'h01, 3'b001, 1'b0, 1'b0, 1'b0);
    go(8'h40, 3'b001, 1'b0, 1'b0, 1'b0); idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule